// File: doc/BRIEF.md
# Memory Data Width Converter

This block links a 32-bit application data path to a memory data bus whose width is chosen at run time as 32, 16 or 8 bits. On the write path, each application word and its byte selects are cut into one, two or four beats, least significant part first. Each beat carries the matching active-low byte mask. On the read path, narrow beats are collected back into 32-bit words. A one-cycle strobe marks each completed word.

The two paths run independently and share one latched width setting. That setting only follows the width select input while both paths are between words. Narrow beats use the low lanes of the memory buses. On writes, the unused data lanes are driven to zero and the unused mask bits to one. On reads, the upper lanes of the memory data are ignored in narrow modes.

Top module: `mem_width_conv`

## Requirements
- R1: The width select encoding is: 2'b00 gives a 32-bit memory (one beat per word), 2'b01 gives 16-bit (two beats), and 2'b10 or 2'b11 gives 8-bit (four beats).
- R2: In 16-bit mode a write word leaves as bits [15:0] and then bits [31:16], on mem_wr_data[15:0], with mem_wr_data[31:16] driven to zero.
- R3: In 8-bit mode a write word leaves as byte 0, byte 1, byte 2 and then byte 3, on mem_wr_data[7:0], with mem_wr_data[31:8] driven to zero.
- R4: mem_wr_mask_n is the inverse of the byte selects of the bytes in the current beat. In 32-bit mode it is all four bits. In 16-bit mode, mask_n[1:0] carries the two bits of the current half. In 8-bit mode, mask_n[0] carries the bit of the current byte. Mask bits that are not used read 1.
- R5: A beat is taken when mem_wr_valid and mem_wr_next are both high. The beat position advances only on a take. app_wr_next is high exactly in the cycle where the final beat of a word is taken.
- R6: Read beats fill the word from the low lane upward. One clock after the final beat is presented with mem_rd_valid, app_rd_valid pulses high for one cycle with the assembled word on app_rd_data.
- R7: app_rd_last equals mem_rd_last of the final beat of a word, is low whenever app_rd_valid is low, and ignores mem_rd_last on non-final beats.
- R8: The latched width follows width_sel one clock later, but only while neither path is partway through a word. A change of width_sel in the middle of a word has no effect on that word.
- R9: Reset clears both beat positions and any partly assembled read word, drives app_rd_valid and app_rd_last low, and sets the latched width to 32-bit.
- R10: In narrow modes the bits of mem_rd_data above the active lane do not affect the assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Memory width select |
| app_wr_valid | input | 1 | Application write word present |
| app_wr_data | input | 32 | Application write word |
| app_wr_be | input | 4 | Active-high byte selects of the write word |
| app_wr_next | output | 1 | Write word fully consumed |
| mem_wr_valid | output | 1 | Write beat present |
| mem_wr_data | output | 32 | Write beat data, low lanes in narrow modes |
| mem_wr_mask_n | output | 4 | Active-low byte mask of the beat |
| mem_wr_next | input | 1 | Memory takes the current write beat |
| mem_rd_valid | input | 1 | Read beat present |
| mem_rd_data | input | 32 | Read beat data, low lanes in narrow modes |
| mem_rd_last | input | 1 | Beat ends a read burst |
| app_rd_valid | output | 1 | Assembled read word strobe |
| app_rd_data | output | 32 | Assembled read word |
| app_rd_last | output | 1 | Word ends a read burst |

## Verification
The assertions assume that the memory side only raises mem_wr_next while a write word is offered. They also assume that the bench holds app_wr_data and app_wr_be steady until app_wr_next. The stimulus meets both conditions: it offers each word from first beat to last without withdrawing it, and it inserts stalls only by lowering mem_wr_next. Width changes are made between words with idle cycles, except in one directed case that checks the mid-word change is ignored. Read beats in narrow modes carry filler in the upper lanes, and mem_rd_last is toggled on non-final beats.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    function automatic logic [1:0] final_beat(input logic [1:0] w);
        logic [1:0] r;
        case (w)
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [1:0] beat;
    } wr_state_t;

    typedef struct packed {
        logic [1:0]  beat;
        logic [31:0] acc;
        logic [31:0] word;
        logic        vld;
        logic        last;
    } rd_state_t;

    typedef struct packed {
        logic [1:0] width;
    } top_state_t;

endpackage

// File: rtl/mwc_wr_split.sv
module mwc_wr_split
    import mwc_pkg::*;
#(
    parameter int APP_DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           width,
    input  logic                 app_wr_valid,
    input  logic [APP_DW-1:0]    app_wr_data,
    input  logic [APP_DW/8-1:0]  app_wr_be,
    output logic                 app_wr_next,
    output logic                 mem_wr_valid,
    output logic [APP_DW-1:0]    mem_wr_data,
    output logic [APP_DW/8-1:0]  mem_wr_mask_n,
    input  logic                 mem_wr_next,
    output logic                 busy
);
    localparam int NB   = APP_DW / 8;
    localparam int HALF = APP_DW / 2;
    localparam int QTR  = APP_DW / 4;
    localparam int HB   = NB / 2;
    localparam int QB   = NB / 4;

    wr_state_t st_q, st_d;
    logic      take;
    logic      at_end;

    always_comb begin
        st_d          = st_q;
        take          = app_wr_valid && mem_wr_next;
        at_end        = (st_q.beat == final_beat(width));
        mem_wr_valid  = app_wr_valid;
        mem_wr_data   = '0;
        mem_wr_mask_n = '1;
        case (width)
            2'b00: begin
                mem_wr_data   = app_wr_data;
                mem_wr_mask_n = ~app_wr_be;
            end
            2'b01: begin
                mem_wr_data[HALF-1:0]  = app_wr_data[int'(st_q.beat[0])*HALF +: HALF];
                mem_wr_mask_n[HB-1:0]  = ~app_wr_be[int'(st_q.beat[0])*HB +: HB];
            end
            default: begin
                mem_wr_data[QTR-1:0]   = app_wr_data[int'(st_q.beat)*QTR +: QTR];
                mem_wr_mask_n[QB-1:0]  = ~app_wr_be[int'(st_q.beat)*QB +: QB];
            end
        endcase
        app_wr_next = take && at_end;
        if (take) begin
            st_d.beat = at_end ? 2'd0 : st_q.beat + 2'd1;
        end
        busy = (st_q.beat != 2'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WR_NEXT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_next |=> (st_q.beat == 2'd0)); // R5
    AST_WR_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (app_wr_valid && !mem_wr_next) |=> $stable(st_q.beat)); // R5
    AST_WR_SPARE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (width != 2'b00) |-> (&mem_wr_mask_n[NB-1:HB])); // R4

endmodule

// File: rtl/mwc_rd_pack.sv
module mwc_rd_pack
    import mwc_pkg::*;
#(
    parameter int APP_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width,
    input  logic              mem_rd_valid,
    input  logic [APP_DW-1:0] mem_rd_data,
    input  logic              mem_rd_last,
    output logic              app_rd_valid,
    output logic [APP_DW-1:0] app_rd_data,
    output logic              app_rd_last,
    output logic              busy
);
    localparam int HALF = APP_DW / 2;
    localparam int QTR  = APP_DW / 4;

    rd_state_t         st_q, st_d;
    logic [APP_DW-1:0] placed;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.last = 1'b0;
        placed    = st_q.acc;
        case (width)
            2'b00:   placed = mem_rd_data;
            2'b01:   placed[int'(st_q.beat[0])*HALF +: HALF] = mem_rd_data[HALF-1:0];
            default: placed[int'(st_q.beat)*QTR +: QTR]      = mem_rd_data[QTR-1:0];
        endcase
        if (mem_rd_valid) begin
            if (st_q.beat == final_beat(width)) begin
                st_d.word = placed;
                st_d.vld  = 1'b1;
                st_d.last = mem_rd_last;
                st_d.beat = 2'd0;
                st_d.acc  = '0;
            end else begin
                st_d.acc  = placed;
                st_d.beat = st_q.beat + 2'd1;
            end
        end
        app_rd_valid = st_q.vld;
        app_rd_data  = st_q.word;
        app_rd_last  = st_q.last;
        busy         = (st_q.beat != 2'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RD_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        app_rd_valid |-> $past(mem_rd_valid)); // R6
    AST_RD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rd_valid && width != 2'b00) |=> !app_rd_valid); // R6
    AST_RD_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        app_rd_last |-> app_rd_valid); // R7

endmodule

// File: rtl/mem_width_conv.sv
module mem_width_conv
    import mwc_pkg::*;
#(
    parameter int APP_DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           width_sel,
    input  logic                 app_wr_valid,
    input  logic [APP_DW-1:0]    app_wr_data,
    input  logic [APP_DW/8-1:0]  app_wr_be,
    output logic                 app_wr_next,
    output logic                 mem_wr_valid,
    output logic [APP_DW-1:0]    mem_wr_data,
    output logic [APP_DW/8-1:0]  mem_wr_mask_n,
    input  logic                 mem_wr_next,
    input  logic                 mem_rd_valid,
    input  logic [APP_DW-1:0]    mem_rd_data,
    input  logic                 mem_rd_last,
    output logic                 app_rd_valid,
    output logic [APP_DW-1:0]    app_rd_data,
    output logic                 app_rd_last
);
    top_state_t st_q, st_d;
    logic       wr_busy;
    logic       rd_busy;

    always_comb begin
        st_d = st_q;
        if (!wr_busy && !rd_busy) st_d.width = width_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mwc_wr_split #(.APP_DW(APP_DW)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .width         (st_q.width),
        .app_wr_valid  (app_wr_valid),
        .app_wr_data   (app_wr_data),
        .app_wr_be     (app_wr_be),
        .app_wr_next   (app_wr_next),
        .mem_wr_valid  (mem_wr_valid),
        .mem_wr_data   (mem_wr_data),
        .mem_wr_mask_n (mem_wr_mask_n),
        .mem_wr_next   (mem_wr_next),
        .busy          (wr_busy)
    );

    mwc_rd_pack #(.APP_DW(APP_DW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .width        (st_q.width),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_last  (mem_rd_last),
        .app_rd_valid (app_rd_valid),
        .app_rd_data  (app_rd_data),
        .app_rd_last  (app_rd_last),
        .busy         (rd_busy)
    );

    AST_FULL_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.width == 2'b00) |-> (!wr_busy && !rd_busy)); // R1
    AST_WIDTH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_busy) && wr_busy) |-> $stable(st_q.width)); // R8

endmodule

// File: tb/mem_width_conv_tb.sv
`timescale 1ns/1ps
module mem_width_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic        app_wr_valid = 1'b0;
    logic [31:0] app_wr_data = '0;
    logic [3:0]  app_wr_be = '0;
    logic        app_wr_next;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_mask_n;
    logic        mem_wr_next = 1'b0;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_last = 1'b0;
    logic        app_rd_valid;
    logic [31:0] app_rd_data;
    logic        app_rd_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mem_width_conv dut_i (.*);

    // {width[1:0], last, be[3:0], data[31:0]}
    localparam logic [38:0] VEC [8] = '{
        {2'b00, 1'b1, 4'b1111, 32'hDEADBEEF},
        {2'b00, 1'b0, 4'b0101, 32'h01234567},
        {2'b01, 1'b1, 4'b1100, 32'hCAFEF00D},
        {2'b01, 1'b0, 4'b0011, 32'h89ABCDEF},
        {2'b10, 1'b1, 4'b1010, 32'h11223344},
        {2'b10, 1'b0, 4'b0110, 32'hA5C3E781},
        {2'b11, 1'b1, 4'b1001, 32'h76543210},
        {2'b11, 1'b0, 4'b1111, 32'hFEDCBA98}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    endfunction

    task automatic set_width(input logic [1:0] w);
        @(negedge clk);
        width_sel = w;
        repeat (2) @(negedge clk);
    endtask

    // expected beat data and mask for beat k
    function automatic logic [31:0] exp_data(input logic [1:0] w, input logic [31:0] d, input int k);
        int lane = 32 / beats_of(w);
        logic [31:0] m = (lane == 32) ? 32'hFFFFFFFF : ((32'h1 << lane) - 1);
        return (d >> (k * lane)) & m;
    endfunction

    function automatic logic [3:0] exp_mask(input logic [1:0] w, input logic [3:0] be, input int k);
        int nbb = 4 / beats_of(w);
        logic [3:0] r = 4'hF;
        for (int i = 0; i < nbb; i++) r[i] = ~be[k*nbb + i];
        return r;
    endfunction

    task automatic write_word(input logic [1:0] w, input logic [31:0] d, input logic [3:0] be);
        int nb = beats_of(w);
        for (int k = 0; k < nb; k++) begin
            if (k == 1) begin
                @(negedge clk);
                mem_wr_next = 1'b0;
                #1;
                check("R5 stall no next", {31'd0, app_wr_next}, 32'd0);
                check("R2/R3 stall holds beat", mem_wr_data, exp_data(w, d, 1));
            end
            @(negedge clk);
            app_wr_valid = 1'b1; app_wr_data = d; app_wr_be = be; mem_wr_next = 1'b1;
            #1;
            check(w == 2'b01 ? "R2 beat data" : w == 2'b00 ? "R1 word data" : "R3 beat data",
                  mem_wr_data, exp_data(w, d, k));
            check("R4 mask", {28'd0, mem_wr_mask_n}, {28'd0, exp_mask(w, be, k)});
            check("R5 next on final", {31'd0, app_wr_next}, {31'd0, k == nb - 1});
        end
        @(negedge clk);
        app_wr_valid = 1'b0; mem_wr_next = 1'b0;
    endtask

    task automatic read_word(input logic [1:0] w, input logic [31:0] d, input logic lst);
        int nb = beats_of(w);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            mem_rd_valid = 1'b1;
            mem_rd_data  = exp_data(w, d, k) | ((nb == 1) ? 32'd0 : (32'hFFFFFFFF << (32 / nb)));
            mem_rd_last  = (k == nb - 1) ? lst : ~lst;
            #1;
            if (k > 0) check("R6 no early strobe", {31'd0, app_rd_valid}, 32'd0);
        end
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_last = 1'b0; mem_rd_data = '0;
        #1;
        check("R6 strobe", {31'd0, app_rd_valid}, 32'd1);
        check("R6/R10 word", app_rd_data, d);
        check("R7 last", {31'd0, app_rd_last}, {31'd0, lst});
        @(negedge clk);
        #1;
        check("R6 one cycle", {31'd0, app_rd_valid}, 32'd0);
        check("R7 last low", {31'd0, app_rd_last}, 32'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset rd valid", {31'd0, app_rd_valid}, 32'd0);
        check("R9 reset rd last", {31'd0, app_rd_last}, 32'd0);
        check("R9 reset wr next", {31'd0, app_wr_next}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            set_width(VEC[v][38:37]);
            write_word(VEC[v][38:37], VEC[v][31:0], VEC[v][35:32]);
            read_word(VEC[v][38:37], VEC[v][31:0], VEC[v][36]);
        end

        // R8: width change mid-word ignored
        set_width(2'b10);
        @(negedge clk);
        app_wr_valid = 1'b1; app_wr_data = 32'h0A0B0C0D; app_wr_be = 4'hF; mem_wr_next = 1'b1;
        @(negedge clk);
        width_sel = 2'b00;
        for (int k = 1; k < 4; k++) begin
            #1;
            check("R8 width held mid-word", mem_wr_data, exp_data(2'b10, 32'h0A0B0C0D, k));
            check("R8 next timing", {31'd0, app_wr_next}, {31'd0, k == 3});
            @(negedge clk);
        end
        app_wr_valid = 1'b0; mem_wr_next = 1'b0;
        repeat (2) @(negedge clk);
        app_wr_valid = 1'b1; mem_wr_next = 1'b1; app_wr_data = 32'h13579BDF;
        #1;
        check("R8 width taken when idle", mem_wr_data, 32'h13579BDF);
        check("R1 full word one beat", {31'd0, app_wr_next}, 32'd1);
        @(negedge clk);
        app_wr_valid = 1'b0; mem_wr_next = 1'b0;

        // R9: partial read word cleared by reset
        set_width(2'b10);
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = 32'h000000EE;
        @(negedge clk);
        mem_rd_data = 32'h000000DD;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R9 reset drops strobe", {31'd0, app_rd_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        read_word(2'b10, 32'h44332211, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule